// File: doc/BRIEF.md
# AXI Error-Response Target

This block is an AXI4 target that stands in for every request that maps to no real slave. Any write burst sent to it is drained beat by beat until the beat marked last. The block then returns one write response carrying an error code. Any read burst sent to it receives exactly as many error read beats as its length field asks for. The final beat is marked last. Every response carries the transaction ID of the request that caused it.

The read side and the write side are independent. Each side holds one burst at a time. A side does not accept a new address until the response of its current burst has been fully taken. Data payloads are never stored. Read data is driven to zero. An interconnect routes unmapped requests here, so that a master always sees a protocol-correct, length-matched error instead of a hang.

Top module: `axi_err_slave`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and in the first cycle after it is released, `b_valid_o` and `r_valid_o` are low and `aw_ready_o` and `ar_ready_o` are high. A reset that arrives during a read burst discards the remaining beats at once.
- R2: After a write address handshake, `w_ready_o` is high and `aw_ready_o` is low on every cycle, until the data beat with `w_last_i` high has been accepted. Beats without `w_last_i` may arrive with gaps.
- R3: `b_valid_o` stays low while data beats are still due. It rises in the cycle after the handshake of the beat with `w_last_i` high. While it is high, `b_resp_o` is 2'b11 and `b_id_o` equals the `aw_id_i` value sampled at the address handshake.
- R4: While `b_valid_o` is high and `b_ready_i` is low, `b_valid_o` and `b_id_o` hold their values, and both `aw_ready_o` and `w_ready_o` are low.
- R5: In the cycle after the write response handshake, `b_valid_o` is low and `aw_ready_o` is high.
- R6: After a read address handshake with length field L, `r_valid_o` is high in the next cycle. Exactly L+1 beats are then delivered. `r_last_o` is high on the final beat only. In the cycle after the final beat is taken, `r_valid_o` is low and `ar_ready_o` is high.
- R7: On every read beat, `r_resp_o` is 2'b11, `r_data_o` is zero, and `r_id_o` equals the `ar_id_i` value sampled at the address handshake.
- R8: While any read beat is outstanding, `ar_ready_o` is low. A beat that is stalled by `r_ready_i` low keeps `r_valid_o`, `r_id_o` and `r_last_o` stable.
- R9: A length field of 255 produces 256 beats, without counter wrap.
- R10: Read and write bursts in flight at the same time do not disturb each other's beat counts or IDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address ready |
| aw_id_i | input | ID_W | Write transaction ID |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data ready |
| w_last_i | input | 1 | Final write data beat |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response ready |
| b_id_o | output | ID_W | Write response ID |
| b_resp_o | output | 2 | Write response code (always 2'b11) |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address ready |
| ar_id_i | input | ID_W | Read transaction ID |
| ar_len_i | input | LEN_W | Read burst length minus one |
| r_valid_o | output | 1 | Read data valid |
| r_ready_i | input | 1 | Read data ready |
| r_id_o | output | ID_W | Read data ID |
| r_data_o | output | DATA_W | Read data (always zero) |
| r_resp_o | output | 2 | Read response code (always 2'b11) |
| r_last_o | output | 1 | Final read beat |

## Verification
The bound checker watches several properties on every cycle:
- the fixed error codes and the zero read data;
- the hold of valid and ID under backpressure on both response channels;
- the address-ready lockout while a response is pending;
- the one-cycle turnarounds from the last write beat to the response, from the read address to the first beat, and from the final read beat back to idle.

Some behaviour can only be shown by the directed scenarios. These cover the exact beat count per burst, including the 256-beat maximum, and that RLAST falls on the correct beat. They also confirm that the echoed ID is the value captured at the handshake rather than the current input, the recovery from reset in the middle of a burst, and that concurrent read and write traffic does not interfere.

// File: rtl/axi_err_pkg.sv
package axi_err_pkg;
  localparam logic [1:0] RESP_ERR = 2'b11;

  typedef enum logic [1:0] {
    WR_ADDR = 2'd0,
    WR_DATA = 2'd1,
    WR_RESP = 2'd2
  } wr_state_e;
endpackage

// File: rtl/axi_err_wr.sv
module axi_err_wr
  import axi_err_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            aw_valid_i,
  output logic            aw_ready_o,
  input  logic [ID_W-1:0] aw_id_i,
  input  logic            w_valid_i,
  output logic            w_ready_o,
  input  logic            w_last_i,
  output logic            b_valid_o,
  input  logic            b_ready_i,
  output logic [ID_W-1:0] b_id_o,
  output logic [1:0]      b_resp_o
);
  wr_state_e       state_q, state_d;
  logic [ID_W-1:0] id_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WR_ADDR: if (aw_valid_i)             state_d = WR_DATA;
      WR_DATA: if (w_valid_i && w_last_i)  state_d = WR_RESP;
      WR_RESP: if (b_ready_i)              state_d = WR_ADDR;
      default:                             state_d = WR_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_ADDR;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == WR_ADDR && aw_valid_i) id_q <= aw_id_i;
    end
  end

  // ID is held in id_q for the whole burst, so AW stays closed until B is taken
  assign aw_ready_o = (state_q == WR_ADDR);
  assign w_ready_o  = (state_q == WR_DATA);
  assign b_valid_o  = (state_q == WR_RESP);
  assign b_id_o     = id_q;
  assign b_resp_o   = RESP_ERR;
endmodule

// File: rtl/axi_err_rd.sv
module axi_err_rd
  import axi_err_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ID_W-1:0]   ar_id_i,
  input  logic [LEN_W-1:0]  ar_len_i,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic [ID_W-1:0]   r_id_o,
  output logic [DATA_W-1:0] r_data_o,
  output logic [1:0]        r_resp_o,
  output logic              r_last_o
);
  // one extra bit so a full-length burst count fits without wrap
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] left_q;
  logic [ID_W-1:0]  id_q;
  logic             idle;

  assign idle = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      id_q   <= '0;
    end else if (idle) begin
      if (ar_valid_i) begin
        left_q <= {1'b0, ar_len_i} + CNT_ONE;
        id_q   <= ar_id_i;
      end
    end else if (r_ready_i) begin
      left_q <= left_q - CNT_ONE;
    end
  end

  assign ar_ready_o = idle;
  assign r_valid_o  = !idle;
  assign r_last_o   = (left_q == CNT_ONE);
  assign r_id_o     = id_q;
  assign r_data_o   = '0;
  assign r_resp_o   = RESP_ERR;
endmodule

// File: rtl/axi_err_slave.sv
module axi_err_slave #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aw_valid_i,
  output logic              aw_ready_o,
  input  logic [ID_W-1:0]   aw_id_i,
  input  logic              w_valid_i,
  output logic              w_ready_o,
  input  logic              w_last_i,
  output logic              b_valid_o,
  input  logic              b_ready_i,
  output logic [ID_W-1:0]   b_id_o,
  output logic [1:0]        b_resp_o,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ID_W-1:0]   ar_id_i,
  input  logic [LEN_W-1:0]  ar_len_i,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic [ID_W-1:0]   r_id_o,
  output logic [DATA_W-1:0] r_data_o,
  output logic [1:0]        r_resp_o,
  output logic              r_last_o
);
  axi_err_wr #(.ID_W(ID_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .aw_valid_i (aw_valid_i),
    .aw_ready_o (aw_ready_o),
    .aw_id_i    (aw_id_i),
    .w_valid_i  (w_valid_i),
    .w_ready_o  (w_ready_o),
    .w_last_i   (w_last_i),
    .b_valid_o  (b_valid_o),
    .b_ready_i  (b_ready_i),
    .b_id_o     (b_id_o),
    .b_resp_o   (b_resp_o)
  );

  axi_err_rd #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ar_valid_i (ar_valid_i),
    .ar_ready_o (ar_ready_o),
    .ar_id_i    (ar_id_i),
    .ar_len_i   (ar_len_i),
    .r_valid_o  (r_valid_o),
    .r_ready_i  (r_ready_i),
    .r_id_o     (r_id_o),
    .r_data_o   (r_data_o),
    .r_resp_o   (r_resp_o),
    .r_last_o   (r_last_o)
  );
endmodule

// File: rtl/axi_err_slave_chk.sv
module axi_err_slave_chk #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              aw_valid_i,
  input logic              aw_ready_o,
  input logic [ID_W-1:0]   aw_id_i,
  input logic              w_valid_i,
  input logic              w_ready_o,
  input logic              w_last_i,
  input logic              b_valid_o,
  input logic              b_ready_i,
  input logic [ID_W-1:0]   b_id_o,
  input logic [1:0]        b_resp_o,
  input logic              ar_valid_i,
  input logic              ar_ready_o,
  input logic [ID_W-1:0]   ar_id_i,
  input logic [LEN_W-1:0]  ar_len_i,
  input logic              r_valid_o,
  input logic              r_ready_i,
  input logic [ID_W-1:0]   r_id_o,
  input logic [DATA_W-1:0] r_data_o,
  input logic [1:0]        r_resp_o,
  input logic              r_last_o
);
  AST_B_AFTER_WLAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_valid_i && w_ready_o && w_last_i |=> b_valid_o) else $error("b late");  // R3
  AST_B_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o |-> b_resp_o == 2'b11) else $error("b code");  // R3
  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o && !b_ready_i |=> b_valid_o && $stable(b_id_o)) else $error("b hold");  // R4
  AST_B_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o |-> !aw_ready_o && !w_ready_o) else $error("b lockout");  // R4
  AST_B_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o && b_ready_i |=> aw_ready_o && !b_valid_o) else $error("b release");  // R5
  AST_R_AFTER_AR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_i && ar_ready_o |=> r_valid_o) else $error("r late");  // R6
  AST_R_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && r_ready_i && r_last_o |=> !r_valid_o && ar_ready_o) else $error("r end");  // R6
  AST_R_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o |-> r_resp_o == 2'b11 && r_data_o == '0) else $error("r code");  // R7
  AST_R_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o |-> !ar_ready_o) else $error("r lockout");  // R8
  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i |=> r_valid_o && $stable(r_id_o) && $stable(r_last_o))
    else $error("r hold");  // R8
endmodule

bind axi_err_slave axi_err_slave_chk #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/axi_err_slave_tb_top.sv
module axi_err_slave_tb_top;
  localparam int ID_W = 4, LEN_W = 8, DATA_W = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic aw_valid_i = 0, w_valid_i = 0, w_last_i = 0, b_ready_i = 0;
  logic ar_valid_i = 0, r_ready_i = 0;
  logic [ID_W-1:0] aw_id_i = '0, ar_id_i = '0;
  logic [LEN_W-1:0] ar_len_i = '0;
  logic aw_ready_o, w_ready_o, b_valid_o, ar_ready_o, r_valid_o, r_last_o;
  logic [ID_W-1:0] b_id_o, r_id_o;
  logic [1:0] b_resp_o, r_resp_o;
  logic [DATA_W-1:0] r_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  axi_err_slave #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [ID_W-1:0] id, input int beats,
                          input int gap_mod, input int b_stall);
    int i;
    @(negedge clk_i);
    aw_valid_i = 1; aw_id_i = id;
    #1;
    while (!aw_ready_o) begin @(negedge clk_i); #1; end
    i = 0;
    while (i < beats) begin
      bit gap;
      @(negedge clk_i);
      aw_valid_i = 0; aw_id_i = ~id;
      gap = (gap_mod != 0) && ($urandom_range(0, gap_mod) == 0);
      w_valid_i = !gap; w_last_i = (i == beats - 1);
      #1;
      chk(w_ready_o && !aw_ready_o, "R2", "w_ready/aw_ready in data", {w_ready_o, aw_ready_o}, 2);
      chk(!b_valid_o, "R3", "b_valid early", b_valid_o, 0);
      if (!gap) i++;
    end
    @(negedge clk_i);
    w_valid_i = 0; w_last_i = 0;
    #1;
    chk(b_valid_o, "R3", "b_valid after last", b_valid_o, 1);
    chk(b_id_o == id, "R3", "b_id", b_id_o, id);
    chk(b_resp_o == 2'b11, "R3", "b_resp", b_resp_o, 3);
    for (int k = 0; k < b_stall; k++) begin
      @(negedge clk_i); #1;
      chk(b_valid_o && b_id_o == id, "R4", "b hold", b_id_o, id);
      chk(!aw_ready_o && !w_ready_o, "R4", "lockout", {aw_ready_o, w_ready_o}, 0);
    end
    @(negedge clk_i); b_ready_i = 1;
    @(negedge clk_i); b_ready_i = 0; #1;
    chk(!b_valid_o && aw_ready_o, "R5", "release", {b_valid_o, aw_ready_o}, 1);
  endtask

  task automatic do_read(input logic [ID_W-1:0] id, input int len, input int stall_mod);
    int n = 0;
    bit seen_last = 0;
    bit prev_stall = 0;
    @(negedge clk_i);
    ar_valid_i = 1; ar_id_i = id; ar_len_i = LEN_W'(len);
    #1;
    while (!ar_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    ar_valid_i = 0; ar_id_i = ~id; ar_len_i = '0;
    #1;
    chk(r_valid_o, "R6", "r_valid after ar", r_valid_o, 1);
    while (!seen_last && n <= len + 1) begin
      bit stall = (stall_mod != 0) && ($urandom_range(0, stall_mod) == 0);
      r_ready_i = !stall;
      #1;
      if (prev_stall) chk(r_valid_o, "R8", "r_valid held", r_valid_o, 1);
      chk(!ar_ready_o, "R8", "ar_ready while busy", ar_ready_o, 0);
      if (r_valid_o && r_ready_i) begin
        n++;
        chk(r_last_o == (n == len + 1), "R6", "r_last position", r_last_o, n == len + 1);
        chk(r_id_o == id, "R7", "r_id", r_id_o, id);
        chk(r_resp_o == 2'b11 && r_data_o == '0, "R7", "r_resp/r_data",
            r_data_o, 0);
        seen_last = r_last_o;
      end
      prev_stall = stall;
      @(negedge clk_i);
    end
    r_ready_i = 0;
    #1;
    chk(n == len + 1, (len == 255) ? "R9" : "R6", "beat count", n, len + 1);
    chk(!r_valid_o && ar_ready_o, "R6", "idle after burst", {r_valid_o, ar_ready_o}, 1);
  endtask

  task automatic t_reset;
    #1;
    chk(!b_valid_o && !r_valid_o, "R1", "valids in reset", {b_valid_o, r_valid_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk(aw_ready_o && ar_ready_o && !b_valid_o && !r_valid_o, "R1", "post reset",
        {aw_ready_o, ar_ready_o, b_valid_o, r_valid_o}, 4'b1100);
  endtask

  task automatic t_reset_mid_read;
    @(negedge clk_i);
    ar_valid_i = 1; ar_id_i = 4'h9; ar_len_i = 8'd10;
    @(negedge clk_i); ar_valid_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 0; #1;
    chk(!r_valid_o && ar_ready_o, "R1", "reset mid burst", {r_valid_o, ar_ready_o}, 1);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i); #1;
    chk(!r_valid_o, "R1", "no beats after reset", r_valid_o, 0);
  endtask

  task automatic t_concurrent;
    fork
      do_write(4'h5, 7, 2, 3);
      do_read(4'hA, 12, 2);
    join
  endtask

  initial begin
    t_reset();
    do_write(4'h3, 1, 0, 0);              // R2 R3 single beat
    do_write(4'hC, 4, 2, 4);              // R4 stalled response
    do_write(4'h7, 16, 1, 1);
    do_read(4'h1, 0, 0);                  // R6 single beat
    do_read(4'hE, 7, 2);                  // R8 with stalls
    do_read(4'h6, 255, 3);                // R9 maximum length
    t_concurrent();                       // R10
    t_reset_mid_read();
    do_read(4'h2, 3, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule